// File: doc/BRIEF.md
# Phase-Aligned Periodic Pulse Output

This block drives one shared timing pin from a free-running time counter. In output mode it makes a square wave with a 50% duty cycle. A start command arms the wave with an absolute start time and a half-period, both in counter ticks. The pin stays low until the counter reaches the start time, goes high at that tick, and then changes level each time another half-period of ticks has passed. With 8 ns ticks the frequency is 1 s / (2 × half-period × 8 ns). The 32-bit half-period gives a longest period of about 68.7 s. A start time that is not later than the current counter value is refused, so the wave can only be armed for a future instant.

The same pin can be turned into an input by selecting capture mode. The output driver is then released and the generator is disarmed. Every rising edge and every falling edge of the pin is timestamped into one capture register. There is no queue and no event flag, so each new edge overwrites the previous value. The input passes through a synchroniser, and the synchroniser latency is subtracted so the captured value is the counter value at the moment the pin changed.

The generator is a three-state machine. IDLE drives the pin low. ARMED drives the pin low and waits for the start time. RUN toggles the pin on each due edge time. The transitions are:
- IDLE to ARMED on an accepted start.
- ARMED to RUN when the counter reaches the start time.
- ARMED or RUN back to ARMED on a new accepted start.
- Any state to IDLE on a stop or on capture mode.

Top module: `phase_pulse_out`

## Requirements
- R1: While reset is asserted, pin_out and pin_oe are 0 and cap_time is 0.
- R2: A start is accepted when cmd_valid is 1 with cmd_word bit 28 set, bit 27 clear, start_time greater than now_time, and half_period nonzero. The pin then stays low until the clock edge at which now_time equals start_time. From the next cycle on, the pin is high.
- R3: After the first rise, the pin changes level each time now_time reaches the previous edge time plus half_period, which gives a 50% duty square wave.
- R4: A start whose start_time is equal to or earlier than now_time has no effect, and the pin stays low.
- R5: cmd_valid with cmd_word bit 27 (stop) set drives pin_out low in the next cycle and disarms the generator.
- R6: When bits 28 and 27 are both set in one command, the stop wins and the wave never starts.
- R7: capture_mode = 1 makes pin_oe and pin_out low in the next cycle and disarms the generator. Returning to capture_mode = 0 drives pin_oe high again, but the pin stays low until a new start is accepted.
- R8: In capture mode, every rising and falling edge on pin_in loads cap_time with the now_time value present when the pin changed, with the synchroniser delay removed. A later edge overwrites the earlier value.
- R9: With capture_mode = 0, edges on pin_in leave cap_time unchanged.
- R10: A start with half_period = 0 is refused, and the pin stays low.
- R11: An accepted start while the wave is running forces the pin low in the next cycle and re-times the wave from the new start_time and half_period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| now_time | input | 64 | Current value of the time counter, in ticks |
| start_time | input | 64 | Absolute time of the first rising edge |
| half_period | input | 32 | Ticks between consecutive pin edges |
| cmd_valid | input | 1 | One-cycle strobe qualifying cmd_word |
| cmd_word | input | 32 | Command; bit 28 = start, bit 27 = stop |
| capture_mode | input | 1 | 1 = pin is an input for timestamp capture, 0 = pin is the wave output |
| pin_in | input | 1 | Level sensed on the pin |
| pin_out | output | 1 | Level driven on the pin |
| pin_oe | output | 1 | Output enable for the pin driver |
| cap_time | output | 64 | Time of the last captured pin edge |

## Verification
The wave is armed with several start offsets and half-periods, including a half-period of 1. Each trace is compared tick by tick against a model of the edge times, so an off-by-one in the start comparison or in the edge advance shows up as a level error at one exact tick. Separate runs issue a start in the present and in the past, a start with zero half-period, and a start with both command bits set; each of these must leave the pin low through the whole window. Restart, stop and mode switches are issued both while the pin is high and while it is low. Capture is exercised with single edges and with edges three ticks apart, which separates a correct latency correction from an off-by-N error and shows that a later edge overwrites the register.

// File: rtl/ppo_pkg.sv
package ppo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } wave_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } cmd_req_t;

endpackage

// File: rtl/ppo_cmd_decode.sv
module ppo_cmd_decode
    import ppo_pkg::*;
#(
    parameter int TIME_W    = 64,
    parameter int HALF_W    = 32,
    parameter int CMD_W     = 32,
    parameter int START_BIT = 28,
    parameter int STOP_BIT  = 27
) (
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [TIME_W-1:0] start_time,
    input  logic [TIME_W-1:0] now_time,
    input  logic [HALF_W-1:0] half_period,
    output cmd_req_t          req
);

    logic future_ok;
    logic half_ok;
    logic cmd_unused;

    // The remaining command bits belong to other functions.
    assign cmd_unused = ^cmd_word;

    assign future_ok = (start_time > now_time);
    assign half_ok   = (half_period != '0);

    always_comb begin
        req.stop  = cmd_valid && cmd_word[STOP_BIT];
        req.start = cmd_valid && cmd_word[START_BIT] && !cmd_word[STOP_BIT]
                    && future_ok && half_ok;
    end

endmodule

// File: rtl/ppo_wave_fsm.sv
module ppo_wave_fsm
    import ppo_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_req_t          req,
    input  logic              capture_mode,
    input  logic [TIME_W-1:0] start_time,
    input  logic [HALF_W-1:0] half_period,
    input  logic [TIME_W-1:0] now_time,
    output logic              pin_out,
    output logic              pin_oe
);

    localparam int PAD_W = TIME_W - HALF_W;

    wave_state_e       state_q, state_nx;
    logic [TIME_W-1:0] edge_q;
    logic [HALF_W-1:0] half_q;
    logic              pin_q;
    logic              oe_q;
    logic              due;
    logic              active;

    assign due    = (now_time >= edge_q);
    assign active = (state_q != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (capture_mode || req.stop) begin
            state_nx = ST_IDLE;
        end else if (req.start) begin
            state_nx = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARMED: if (due) state_nx = ST_RUN;
                ST_RUN:   state_nx = ST_RUN;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // Output and edge-time registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            oe_q   <= 1'b0;
            edge_q <= '0;
            half_q <= '0;
        end else begin
            oe_q <= !capture_mode;
            if (capture_mode || req.stop) begin
                pin_q <= 1'b0;
            end else if (req.start) begin
                pin_q  <= 1'b0;
                edge_q <= start_time;
                half_q <= half_period;
            end else if (active && due) begin
                pin_q  <= !pin_q;
                edge_q <= edge_q + {{PAD_W{1'b0}}, half_q};
            end
        end
    end

    assign pin_out = pin_q;
    assign pin_oe  = oe_q;

endmodule

// File: rtl/ppo_edge_capture.sv
module ppo_edge_capture #(
    parameter int TIME_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_mode,
    input  logic              pin_in,
    input  logic [TIME_W-1:0] now_time,
    output logic [TIME_W-1:0] cap_time
);

    localparam logic [TIME_W-1:0] LATENCY = TIME_W'(SYNC_STAGES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_seen;
    logic [TIME_W-1:0]      cap_q;

    // Synchroniser chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
    end

    // Edge detect on the last synchroniser stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;

    // Single capture slot, overwritten by every edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cap_q <= '0;
        else if (capture_mode && edge_seen) cap_q <= now_time - LATENCY;
    end

    assign cap_time = cap_q;

endmodule

// File: rtl/phase_pulse_out.sv
module phase_pulse_out
    import ppo_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int HALF_W      = 32,
    parameter int CMD_W       = 32,
    parameter int START_BIT   = 28,
    parameter int STOP_BIT    = 27,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] start_time,
    input  logic [HALF_W-1:0] half_period,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              capture_mode,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic [TIME_W-1:0] cap_time
);

    cmd_req_t req;

    ppo_cmd_decode #(
        .TIME_W(TIME_W), .HALF_W(HALF_W), .CMD_W(CMD_W),
        .START_BIT(START_BIT), .STOP_BIT(STOP_BIT)
    ) u_decode (
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .start_time (start_time),
        .now_time   (now_time),
        .half_period(half_period),
        .req        (req)
    );

    ppo_wave_fsm #(
        .TIME_W(TIME_W), .HALF_W(HALF_W)
    ) u_wave (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .capture_mode(capture_mode),
        .start_time  (start_time),
        .half_period (half_period),
        .now_time    (now_time),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    ppo_edge_capture #(
        .TIME_W(TIME_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_mode(capture_mode),
        .pin_in      (pin_in),
        .now_time    (now_time),
        .cap_time    (cap_time)
    );

endmodule

// File: rtl/phase_pulse_out_checker.sv
module phase_pulse_out_checker #(
    parameter int TIME_W    = 64,
    parameter int HALF_W    = 32,
    parameter int CMD_W     = 32,
    parameter int START_BIT = 28,
    parameter int STOP_BIT  = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] now_time,
    input logic [TIME_W-1:0] start_time,
    input logic [HALF_W-1:0] half_period,
    input logic              cmd_valid,
    input logic [CMD_W-1:0]  cmd_word,
    input logic              capture_mode,
    input logic              pin_out,
    input logic              pin_oe,
    input logic [TIME_W-1:0] cap_time
);

    AST_STOP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[STOP_BIT]) |=> !pin_out); // R5

    AST_BOTH_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[STOP_BIT] && cmd_word[START_BIT]) |=> !pin_out); // R6

    AST_CAPTURE_RELEASES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        capture_mode |=> (!pin_oe && !pin_out)); // R7

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_out |-> pin_oe); // R7

    AST_CAP_HOLD_OUTPUT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_mode |=> $stable(cap_time)); // R9

    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[START_BIT] && (start_time > now_time)
         && (half_period != '0)) |=> !pin_out); // R11

endmodule

bind phase_pulse_out phase_pulse_out_checker #(
    .TIME_W(TIME_W), .HALF_W(HALF_W), .CMD_W(CMD_W),
    .START_BIT(START_BIT), .STOP_BIT(STOP_BIT)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .now_time    (now_time),
    .start_time  (start_time),
    .half_period (half_period),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .capture_mode(capture_mode),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .cap_time    (cap_time)
);

// File: tb/test_phase_pulse_out.sv
`timescale 1ns/1ps
module test_phase_pulse_out;

    localparam logic [63:0] NEVER = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now_t = 64'd100;
    logic [63:0] start_t = '0;
    logic [31:0] half_t = '0;
    logic        cmd_v = 1'b0;
    logic [31:0] cmd_w = '0;
    logic        cap_m = 1'b0;
    logic        pin_i = 1'b0;
    logic        pin_o;
    logic        oe_o;
    logic [63:0] cap_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    phase_pulse_out i_phase_pulse_out (
        .clk(clk), .rst_n(rst_n), .now_time(now_t), .start_time(start_t),
        .half_period(half_t), .cmd_valid(cmd_v), .cmd_word(cmd_w),
        .capture_mode(cap_m), .pin_in(pin_i), .pin_out(pin_o),
        .pin_oe(oe_o), .cap_time(cap_o)
    );

    function automatic logic model_level(logic [63:0] t, logic [63:0] s, logic [31:0] h);
        if (h == 0 || t < s) return 1'b0;
        return (((t - s) / {32'd0, h}) % 2) == 0;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d at now=%0d", req, act, exp, now_t);
        end
    endtask

    task automatic issue(input logic st, input logic sp, input logic [63:0] s,
                         input logic [31:0] h);
        @(negedge clk);
        start_t = s;
        half_t  = h;
        cmd_w   = '0;
        cmd_w[28] = st;
        cmd_w[27] = sp;
        cmd_v   = 1'b1;
    endtask

    task automatic run_wave(input int n, input logic [63:0] s, input logic [31:0] h,
                            input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_v = 1'b0;
            check(pin_o == model_level(now_t, s, h), req, pin_o, model_level(now_t, s, h));
            now_t = now_t + 1;
        end
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_v = 1'b0;
            now_t = now_t + 1;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(pin_o == 1'b0, "R1", pin_o, 0);
        check(oe_o == 1'b0, "R1", oe_o, 0);
        check(cap_o == 64'd0, "R1", cap_o, 0);
        rst_n = 1'b1;
        idle_ticks(2);
        check(oe_o == 1'b1, "R7", oe_o, 1);
    endtask

    task automatic t_basic_wave;
        logic [63:0] s;
        s = now_t + 5;
        issue(1'b1, 1'b0, s, 32'd3);
        run_wave(30, s, 32'd3, "R2");
        s = now_t + 2;
        issue(1'b1, 1'b0, s, 32'd1);
        run_wave(12, s, 32'd1, "R3");
        s = now_t + 9;
        issue(1'b1, 1'b0, s, 32'd7);
        run_wave(40, s, 32'd7, "R3");
    endtask

    task automatic t_restart;
        logic [63:0] s;
        s = now_t + 3;
        issue(1'b1, 1'b0, s, 32'd6);
        run_wave(5, s, 32'd6, "R3");
        check(pin_o == 1'b1, "R11", pin_o, 1);
        s = now_t + 7;
        issue(1'b1, 1'b0, s, 32'd2);
        run_wave(24, s, 32'd2, "R11");
    endtask

    task automatic t_stop;
        logic [63:0] s;
        s = now_t + 4;
        issue(1'b1, 1'b0, s, 32'd5);
        run_wave(7, s, 32'd5, "R3");
        check(pin_o == 1'b1, "R5", pin_o, 1);
        issue(1'b0, 1'b1, 64'd0, 32'd0);
        run_wave(20, NEVER, 32'd1, "R5");
    endtask

    task automatic t_both_bits;
        issue(1'b1, 1'b1, now_t + 3, 32'd2);
        run_wave(15, NEVER, 32'd1, "R6");
    endtask

    task automatic t_late_start;
        issue(1'b1, 1'b0, now_t, 32'd3);
        run_wave(10, NEVER, 32'd1, "R4");
        issue(1'b1, 1'b0, now_t - 1, 32'd3);
        run_wave(10, NEVER, 32'd1, "R4");
    endtask

    task automatic t_zero_half;
        issue(1'b1, 1'b0, now_t + 3, 32'd0);
        run_wave(10, NEVER, 32'd1, "R10");
    endtask

    task automatic t_capture_disarms;
        logic [63:0] s;
        s = now_t + 3;
        issue(1'b1, 1'b0, s, 32'd4);
        run_wave(5, s, 32'd4, "R3");
        check(pin_o == 1'b1, "R7", pin_o, 1);
        @(negedge clk);
        cap_m = 1'b1;
        idle_ticks(2);
        check(oe_o == 1'b0, "R7", oe_o, 0);
        check(pin_o == 1'b0, "R7", pin_o, 0);
        @(negedge clk);
        cap_m = 1'b0;
        idle_ticks(1);
        check(oe_o == 1'b1, "R7", oe_o, 1);
        run_wave(16, NEVER, 32'd1, "R7");
    endtask

    task automatic pin_change(input logic v, output logic [63:0] at);
        @(negedge clk);
        now_t = now_t + 1;
        pin_i = v;
        at = now_t;
    endtask

    task automatic t_capture;
        logic [63:0] n1;
        logic [63:0] n2;
        @(negedge clk);
        cap_m = 1'b1;
        idle_ticks(3);
        pin_change(1'b1, n1);
        idle_ticks(5);
        check(cap_o == n1, "R8", cap_o, n1);
        pin_change(1'b0, n1);
        idle_ticks(5);
        check(cap_o == n1, "R8", cap_o, n1);
        pin_change(1'b1, n1);
        idle_ticks(2);
        pin_change(1'b0, n2);
        idle_ticks(6);
        check(cap_o == n2, "R8", cap_o, n2);
        check(n2 == n1 + 3, "R8", n2, n1 + 3);
        check(oe_o == 1'b0, "R7", oe_o, 0);
    endtask

    task automatic t_output_mode_ignore;
        logic [63:0] held;
        logic [63:0] dummy;
        @(negedge clk);
        cap_m = 1'b0;
        idle_ticks(2);
        held = cap_o;
        pin_change(1'b1, dummy);
        idle_ticks(6);
        check(cap_o == held, "R9", cap_o, held);
        pin_change(1'b0, dummy);
        idle_ticks(6);
        check(cap_o == held, "R9", cap_o, held);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_wave();
        t_restart();
        t_stop();
        t_both_bits();
        t_late_start();
        t_zero_half();
        t_capture_disarms();
        t_capture();
        t_output_mode_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule